// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Logic

This block keeps the status byte of a byte-oriented I2C controller that a host processor reads and writes over a parallel bus. The serial engine sends it single-cycle event pulses: byte finished (nine SCL pulses including the acknowledge), START seen, STOP seen, misplaced START/STOP, arbitration lost, own-address match and general-call match. It also sends the level of the last bit received. The host interface sends single-cycle strobes for a data-register write, a data-register read and a control write. The control write carries a START request bit and an interrupt-enable bit.

An active-low service flag is the centre of the block. The engine drives it low when the host has work to do. A host action that starts or continues a transfer drives it high again, and that rising edge wipes every other status flag. The flag also drives the active-low interrupt pin and, in slave mode, a request to hold SCL low. Bus-busy tracking is kept in the same byte. All pins are plain level or pulse signals. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_stat_top`

## Requirements
- R1: After reset `status_byte` is 8'h81, `irq_n` is 1, `busy_n` is 1 and `scl_hold` is 0. The byte layout is: bit 7 service flag (0 = service needed), bit 6 slave STOP seen, bit 5 bus error, bit 4 shared last-bit/general-call bit, bit 3 addressed as slave, bit 2 arbitration lost, bit 1 always 0, bit 0 copy of `busy_n`.
- R2: A control write with `host_ctl_start` = 1 sets bit 7 to 1. A control write with `host_ctl_start` = 0 leaves bit 7 unchanged.
- R3: With `mode_tx` = 1, a data write sets bit 7 to 1. With `mode_tx` = 0, a data read sets bit 7 to 1. A data write while `mode_tx` = 0 has no effect on the byte.
- R4: A byte-finished pulse clears bit 7 to 0 in the next cycle.
- R5: When bit 7 goes from 0 to 1, bits 6 to 2 become 0. Bit 0 is not touched.
- R6: A bus-error pulse sets bit 5, clears bit 7 and sets `busy_n` to 1.
- R7: While the stored interrupt enable (loaded on each control write) is 1 and bit 7 is 0, `irq_n` is 0. Otherwise it is 1.
- R8: `scl_hold` is 1 exactly when `mode_slave` = 1 and bit 7 is 0.
- R9: A STOP pulse in slave receive mode (`mode_slave` = 1, `mode_tx` = 0) sets bit 6 and clears bit 7. In master mode the same pulse leaves bits 7 and 6 unchanged.
- R10: An own-address match sets bit 3 and forces bit 4 to 0. A general-call match sets bit 3 and forces bit 4 to 1.
- R11: On a byte-finished pulse while bit 3 is 0, bit 4 takes the value of `rx_last_bit`.
- R12: An arbitration-lost pulse sets bit 2.
- R13: A START pulse clears `busy_n` to 0. A STOP pulse sets it to 1.
- R14: If an event that clears bit 7 arrives in the same cycle as a host strobe that sets it, bit 7 ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_byte_done | input | 1 | Pulse: nine-clock byte transfer finished |
| evt_start | input | 1 | Pulse: valid START seen on the bus |
| evt_stop | input | 1 | Pulse: STOP seen on the bus |
| evt_bus_err | input | 1 | Pulse: misplaced START or STOP |
| evt_arb_lost | input | 1 | Pulse: arbitration lost to another master |
| evt_own_match | input | 1 | Pulse: received address equals own address |
| evt_gen_call | input | 1 | Pulse: received address is general call |
| rx_last_bit | input | 1 | Last bit received, sampled with byte-finished |
| mode_slave | input | 1 | Engine operating as slave |
| mode_tx | input | 1 | Engine operating as transmitter |
| host_dat_wr | input | 1 | Pulse: host wrote the data register |
| host_dat_rd | input | 1 | Pulse: host read the data register |
| host_ctl_wr | input | 1 | Pulse: host wrote the control register |
| host_ctl_start | input | 1 | START request bit of the control write |
| host_ctl_ien | input | 1 | Interrupt enable bit of the control write |
| status_byte | output | 8 | Status byte as the host reads it |
| irq_n | output | 1 | Active-low interrupt |
| busy_n | output | 1 | Active-low bus busy |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The assertions assume that every event and strobe input is a one-cycle pulse aligned to `clk`. They also assume that the mode levels change only between transfers and that `rx_last_bit` is valid in the cycle of the byte-finished pulse. The bench drives every input at the falling edge and holds each pulse for exactly one period. Mode levels are changed only while no pulse is active. Coincident pulses appear only in the cases the requirements name: address match together with byte-finished, and a clear event together with a host strobe.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int B_SVC_N  = 7;
  localparam int B_STOP   = 6;
  localparam int B_BERR   = 5;
  localparam int B_SHARED = 4;
  localparam int B_ADDR   = 3;
  localparam int B_ARB    = 2;
  localparam int B_BUSY_N = 0;

  typedef struct packed {
    logic stop_seen;
    logic bus_err;
    logic shared_bit;
    logic addr_hit;
    logic arb_lost;
  } flag_t;
endpackage

// File: rtl/i2c_stat_pend.sv
module i2c_stat_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_byte_done,
  input  logic evt_start,
  input  logic evt_stop,
  input  logic evt_bus_err,
  input  logic mode_slave,
  input  logic mode_tx,
  input  logic host_dat_wr,
  input  logic host_dat_rd,
  input  logic host_ctl_wr,
  input  logic host_ctl_start,
  output logic svc_n,
  output logic svc_rise,
  output logic busy_n
);
  logic clr_ev, set_ev;

  assign clr_ev = evt_byte_done | evt_bus_err | (evt_stop & mode_slave & ~mode_tx);
  assign set_ev = (host_ctl_wr & host_ctl_start) | (host_dat_wr & mode_tx) |
                  (host_dat_rd & ~mode_tx);
  assign svc_rise = set_ev & ~clr_ev & ~svc_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_n  <= 1'b1;
      busy_n <= 1'b1;
    end else begin
      if (clr_ev)      svc_n <= 1'b0;
      else if (set_ev) svc_n <= 1'b1;
      if (evt_bus_err || evt_stop) busy_n <= 1'b1;
      else if (evt_start)          busy_n <= 1'b0;
    end
  end

  assert_byte_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_byte_done |=> !svc_n);
  assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ctl_wr && host_ctl_start && !evt_byte_done && !evt_bus_err && !evt_stop) |=> svc_n);
  assert_berr_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bus_err |=> (!svc_n && busy_n));
  assert_event_wins_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_byte_done && (host_dat_wr || host_dat_rd || host_ctl_wr)) |=> !svc_n);
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  svc_rise,
  input  logic  evt_byte_done,
  input  logic  evt_stop,
  input  logic  evt_bus_err,
  input  logic  evt_arb_lost,
  input  logic  evt_own_match,
  input  logic  evt_gen_call,
  input  logic  rx_last_bit,
  input  logic  mode_slave,
  input  logic  mode_tx,
  output flag_t flags
);
  flag_t base, nxt;
  logic  any_set;

  assign any_set = evt_stop | evt_bus_err | evt_arb_lost | evt_own_match |
                   evt_gen_call | evt_byte_done;

  always_comb begin
    base = svc_rise ? '0 : flags;
    nxt  = base;
    if (evt_stop && mode_slave && !mode_tx) nxt.stop_seen = 1'b1;
    if (evt_bus_err)  nxt.bus_err  = 1'b1;
    if (evt_arb_lost) nxt.arb_lost = 1'b1;
    if (evt_own_match || evt_gen_call) nxt.addr_hit = 1'b1;
    if (evt_gen_call)                              nxt.shared_bit = 1'b1;
    else if (evt_own_match)                        nxt.shared_bit = 1'b0;
    else if (evt_byte_done && !base.addr_hit)      nxt.shared_bit = rx_last_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  assert_rise_wipes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_rise && !any_set) |=> (flags == '0));
  assert_gc_shared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_gen_call |=> (flags.addr_hit && flags.shared_bit));
  assert_arb_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    evt_arb_lost |=> flags.arb_lost);
  assert_berr_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bus_err |=> flags.bus_err);
endmodule

// File: rtl/i2c_stat_out.sv
module i2c_stat_out (
  input  logic clk,
  input  logic rst_n,
  input  logic host_ctl_wr,
  input  logic host_ctl_ien,
  input  logic svc_n,
  input  logic mode_slave,
  output logic irq_n,
  output logic scl_hold
);
  logic ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ien_q <= 1'b0;
    else if (host_ctl_wr) ien_q <= host_ctl_ien;
  end

  assign irq_n    = ~(ien_q & ~svc_n);
  assign scl_hold = mode_slave & ~svc_n;

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ctl_wr && !host_ctl_ien) |=> irq_n);
  assert_hold_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_slave || svc_n) |-> !scl_hold);
endmodule

// File: rtl/i2c_stat_top.sv
module i2c_stat_top
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_byte_done,
  input  logic              evt_start,
  input  logic              evt_stop,
  input  logic              evt_bus_err,
  input  logic              evt_arb_lost,
  input  logic              evt_own_match,
  input  logic              evt_gen_call,
  input  logic              rx_last_bit,
  input  logic              mode_slave,
  input  logic              mode_tx,
  input  logic              host_dat_wr,
  input  logic              host_dat_rd,
  input  logic              host_ctl_wr,
  input  logic              host_ctl_start,
  input  logic              host_ctl_ien,
  output logic [STAT_W-1:0] status_byte,
  output logic              irq_n,
  output logic              busy_n,
  output logic              scl_hold
);
  logic  svc_n, svc_rise;
  flag_t flags;

  i2c_stat_pend u_pend (
    .clk(clk), .rst_n(rst_n), .evt_byte_done(evt_byte_done), .evt_start(evt_start),
    .evt_stop(evt_stop), .evt_bus_err(evt_bus_err), .mode_slave(mode_slave),
    .mode_tx(mode_tx), .host_dat_wr(host_dat_wr), .host_dat_rd(host_dat_rd),
    .host_ctl_wr(host_ctl_wr), .host_ctl_start(host_ctl_start),
    .svc_n(svc_n), .svc_rise(svc_rise), .busy_n(busy_n));

  i2c_stat_flags u_flags (
    .clk(clk), .rst_n(rst_n), .svc_rise(svc_rise), .evt_byte_done(evt_byte_done),
    .evt_stop(evt_stop), .evt_bus_err(evt_bus_err), .evt_arb_lost(evt_arb_lost),
    .evt_own_match(evt_own_match), .evt_gen_call(evt_gen_call),
    .rx_last_bit(rx_last_bit), .mode_slave(mode_slave), .mode_tx(mode_tx),
    .flags(flags));

  i2c_stat_out u_out (
    .clk(clk), .rst_n(rst_n), .host_ctl_wr(host_ctl_wr), .host_ctl_ien(host_ctl_ien),
    .svc_n(svc_n), .mode_slave(mode_slave), .irq_n(irq_n), .scl_hold(scl_hold));

  always_comb begin
    status_byte           = '0;
    status_byte[B_SVC_N]  = svc_n;
    status_byte[B_STOP]   = flags.stop_seen;
    status_byte[B_BERR]   = flags.bus_err;
    status_byte[B_SHARED] = flags.shared_bit;
    status_byte[B_ADDR]   = flags.addr_hit;
    status_byte[B_ARB]    = flags.arb_lost;
    status_byte[B_BUSY_N] = busy_n;
  end

  assert_slave_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stop && mode_slave && !mode_tx) |=> (status_byte[B_STOP] && !status_byte[B_SVC_N]));
  assert_busy_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start && !evt_stop && !evt_bus_err) |=> !busy_n);
endmodule

// File: tb/test_i2c_stat_top.sv
module test_i2c_stat_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_byte_done = 0, evt_start = 0, evt_stop = 0, evt_bus_err = 0;
  logic evt_arb_lost = 0, evt_own_match = 0, evt_gen_call = 0, rx_last_bit = 0;
  logic mode_slave = 0, mode_tx = 1;
  logic host_dat_wr = 0, host_dat_rd = 0, host_ctl_wr = 0, host_ctl_start = 0, host_ctl_ien = 0;
  logic [7:0] status_byte;
  logic irq_n, busy_n, scl_hold;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  i2c_stat_top i_i2c_stat_top (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    evt_byte_done = 0; evt_start = 0; evt_stop = 0; evt_bus_err = 0;
    evt_arb_lost = 0; evt_own_match = 0; evt_gen_call = 0;
    host_dat_wr = 0; host_dat_rd = 0; host_ctl_wr = 0; host_ctl_start = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_all();
  endtask

  task automatic byte_done(input logic lb);
    evt_byte_done = 1; rx_last_bit = lb; step();
  endtask

  task automatic ctl(input logic st, input logic ien);
    host_ctl_wr = 1; host_ctl_start = st; host_ctl_ien = ien; step();
  endtask

  task automatic t_reset();
    chk("R1 status", status_byte, 8'h81);
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 busy_n", {7'b0, busy_n}, 8'h01);
    chk("R1 scl_hold", {7'b0, scl_hold}, 8'h00);
  endtask

  task automatic t_tx_lrb();
    mode_slave = 0; mode_tx = 1;
    byte_done(1'b1);
    chk("R4 R11 tx byte", status_byte, 8'h11);
    host_dat_wr = 1; step();
    chk("R3 R5 tx write", status_byte, 8'h81);
  endtask

  task automatic t_rx_read();
    mode_tx = 0;
    byte_done(1'b0);
    chk("R11 rx byte", status_byte, 8'h01);
    host_dat_wr = 1; step();
    chk("R3 write ignored in rx", status_byte, 8'h01);
    host_dat_rd = 1; step();
    chk("R3 rx read", status_byte, 8'h81);
    mode_tx = 1;
  endtask

  task automatic t_ctl_start();
    byte_done(1'b1);
    ctl(1'b0, 1'b0);
    chk("R2 no start", status_byte, 8'h11);
    ctl(1'b1, 1'b0);
    chk("R2 start", status_byte, 8'h81);
  endtask

  task automatic t_addr();
    mode_slave = 1; mode_tx = 0;
    evt_own_match = 1; evt_byte_done = 1; rx_last_bit = 1; step();
    chk("R10 own match", status_byte, 8'h09);
    chk("R8 hold slave", {7'b0, scl_hold}, 8'h01);
    host_dat_rd = 1; step();
    chk("R8 release", {7'b0, scl_hold}, 8'h00);
    evt_gen_call = 1; evt_byte_done = 1; rx_last_bit = 0; step();
    chk("R10 general call", status_byte, 8'h19);
    host_dat_rd = 1; step();
    chk("R5 addr wiped", status_byte, 8'h81);
  endtask

  task automatic t_stop();
    evt_stop = 1; step();
    chk("R9 slave stop", status_byte, 8'h41);
    host_dat_rd = 1; step();
    mode_slave = 0; mode_tx = 1;
    evt_start = 1; step();
    chk("R13 start busy", status_byte, 8'h80);
    chk("R13 busy_n low", {7'b0, busy_n}, 8'h00);
    evt_stop = 1; step();
    chk("R9 R13 master stop", status_byte, 8'h81);
  endtask

  task automatic t_berr();
    evt_start = 1; step();
    evt_bus_err = 1; step();
    chk("R6 bus error", status_byte, 8'h21);
    ctl(1'b1, 1'b0);
    chk("R5 berr wiped", status_byte, 8'h81);
  endtask

  task automatic t_arb();
    evt_arb_lost = 1; step();
    chk("R12 arb lost", status_byte, 8'h85);
    byte_done(1'b0);
    chk("R12 arb kept", status_byte, 8'h05);
    ctl(1'b1, 1'b0);
    chk("R5 arb wiped", status_byte, 8'h81);
  endtask

  task automatic t_irq();
    ctl(1'b0, 1'b1);
    chk("R7 idle", {7'b0, irq_n}, 8'h01);
    byte_done(1'b0);
    chk("R7 asserted", {7'b0, irq_n}, 8'h00);
    chk("R8 master no hold", {7'b0, scl_hold}, 8'h00);
    host_dat_wr = 1; step();
    chk("R7 released", {7'b0, irq_n}, 8'h01);
    ctl(1'b0, 1'b0);
    byte_done(1'b0);
    chk("R7 disabled", {7'b0, irq_n}, 8'h01);
    host_dat_wr = 1; step();
  endtask

  task automatic t_priority();
    evt_byte_done = 1; rx_last_bit = 0; host_dat_wr = 1; step();
    chk("R14 event wins", status_byte, 8'h01);
    host_dat_wr = 1; step();
    chk("R14 recover", status_byte, 8'h81);
  endtask

  initial begin
    #1001;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_tx_lrb();
    t_rx_read();
    t_ctl_start();
    t_addr();
    t_stop();
    t_berr();
    t_arb();
    t_irq();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule